// File: doc/BRIEF.md
# Hardwired Micro-Operation Sequencer with Accumulator Datapath

This block is a small single-register processor core whose control is hardwired. Each instruction is split into a fixed list of register-transfer steps. These steps move words between a memory address register, a memory buffer register, the program counter, the instruction register and one general register. A two-bit cycle code selects the kind of cycle being run. A step counter selects the position inside that cycle, with step value 0 standing for t1. A combinational decoder turns the pair of cycle code and step, together with the opcode, into one control word per clock.

The core drives a synchronous memory port. The address output always shows the memory address register. A read strobe in one cycle makes the memory present the addressed word during the next cycle. A write strobe stores the buffer register at the shown address on the closing clock edge. The core runs three instructions: add-to-register, increment-and-skip-if-zero, and branch-and-save-address. Any of them can take an indirect operand. All other opcodes are skipped.

Top module: `uop_ctrl_core`

## Requirements
- R1: While rst_ni is low and on its release, pc_o, r1_o and ir_o are 0, cyc_o is 00, step_o is 0, and both memory strobes are low.
- R2: The fetch cycle lasts exactly 4 clocks. At step 0 the PC is copied to the address register. At step 1 the read strobe is high with mem_addr_o equal to PC. At step 2 the buffer register takes mem_rdata_i. At step 3 the instruction register is loaded and PC advances by 1 modulo 2^11.
- R3: A read strobe and a write strobe are never high in the same clock, and a write strobe only occurs in the execute cycle.
- R4: The cycle code is 00 for fetch, 01 for indirect and 10 for execute. Code 11 is never entered. Whenever the cycle code changes, the step counter restarts at 0.
- R5: An instruction word holds the opcode in bits 15:12, the indirect flag in bit 11 and the address field in bits 10:0. Opcode 1 is add, opcode 2 is increment-and-skip and opcode 3 is branch-and-save.
- R6: Add sets R1 to R1 plus the operand word, modulo 2^16. Its execute cycle takes 4 clocks, so the whole instruction takes 8 clocks when it is direct.
- R7: Increment-and-skip adds 1 to the operand word and writes the result back to the operand address in the fifth execute step. If the result is 0, PC advances by one extra word. Its execute cycle takes 5 clocks.
- R8: Branch-and-save writes the address of the following instruction, zero-extended to 16 bits, to the operand address and then sets PC to that address plus 1. Its execute cycle takes 4 clocks.
- R9: When bit 11 is set on a known opcode, an indirect cycle of 3 clocks reads the word at the address field. The low 11 bits of that word then become the effective address used by the execute cycle.
- R10: A word whose opcode is not 1, 2 or 3 takes only the 4 fetch clocks, ignores the indirect flag, and leaves R1 and memory unchanged. The next fetch begins directly after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 11 | Memory address, equal to the address register |
| mem_rd_o | output | 1 | Read strobe; data expected on mem_rdata_i in the next clock |
| mem_wr_o | output | 1 | Write strobe; mem_wdata_o is stored at mem_addr_o on the edge |
| mem_wdata_o | output | 16 | Write data, equal to the buffer register |
| mem_rdata_i | input | 16 | Read data returned by memory |
| pc_o | output | 11 | Program counter |
| r1_o | output | 16 | General register R1 |
| ir_o | output | 16 | Instruction register |
| cyc_o | output | 2 | Current cycle code |
| step_o | output | 3 | Current step within the cycle, 0 meaning t1 |

## Verification
The length of every instruction is fixed. Fetch takes 4 clocks, indirect adds 3, and execute adds 4 for add and branch-and-save or 5 for increment-and-skip. A bench-side model therefore predicts, for each instruction, the exact clock in which the next fetch begins. The bench samples on the falling edge one clock after fetch start to check the read strobe and address. It then waits the predicted count and, on the falling edge where the core must be back at fetch step 0, compares PC, R1, the cycle state and any word written to memory. An instruction that ends one clock early or late therefore fails the check.

// File: rtl/uop_pkg.sv
package uop_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_INDIR = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INTR  = 2'b11
  } cyc_e;

  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] OP_ADD = 4'd1;
  localparam logic [OPW-1:0] OP_ISZ = 4'd2;
  localparam logic [OPW-1:0] OP_BSA = 4'd3;

  // datapath register-transfer enables for one step
  typedef struct packed {
    logic mar_ld_pc;
    logic mar_ld_addr;
    logic mbr_ld_mem;
    logic mbr_ld_ptr;
    logic mbr_ld_pc;
    logic mbr_inc;
    logic ir_ld;
    logic pc_inc;
    logic pc_skip_z;
    logic pc_ld_mar1;
    logic r1_add;
  } dp_ctl_t;

  function automatic logic op_known(logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_ISZ) || (op == OP_BSA);
  endfunction

endpackage

// File: rtl/uop_timer.sv
module uop_timer
  import uop_pkg::*;
#(
  parameter int unsigned TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          last_i,
  input  cyc_e          next_i,
  output cyc_e          cyc_o,
  output logic [TW-1:0] step_o
);

  cyc_e          cyc_q;
  logic [TW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_FETCH;
      step_q <= '0;
    end else if (last_i) begin
      cyc_q  <= next_i;
      step_q <= '0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  assign cyc_o  = cyc_q;
  assign step_o = step_q;

endmodule

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
#(
  parameter int unsigned TW = 3
) (
  input  cyc_e           cyc_i,
  input  logic [TW-1:0]  step_i,
  input  logic [OPW-1:0] ir_op_i,
  input  logic [OPW-1:0] mbr_op_i,
  input  logic           mbr_ind_i,
  output dp_ctl_t        dp_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           last_o,
  output cyc_e           next_o
);

  localparam logic [TW-1:0] T1 = TW'(0);
  localparam logic [TW-1:0] T2 = TW'(1);
  localparam logic [TW-1:0] T3 = TW'(2);
  localparam logic [TW-1:0] T4 = TW'(3);
  localparam logic [TW-1:0] T5 = TW'(4);

  always_comb begin
    dp_o     = '0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    last_o   = 1'b0;
    next_o   = CYC_FETCH;
    unique case (cyc_i)
      CYC_FETCH: begin
        case (step_i)
          T1: dp_o.mar_ld_pc = 1'b1;
          T2: mem_rd_o = 1'b1;
          T3: dp_o.mbr_ld_mem = 1'b1;
          T4: begin
            dp_o.ir_ld  = 1'b1;
            dp_o.pc_inc = 1'b1;
            last_o      = 1'b1;
            if (!op_known(mbr_op_i)) next_o = CYC_FETCH;
            else if (mbr_ind_i)      next_o = CYC_INDIR;
            else                     next_o = CYC_EXEC;
          end
          default: last_o = 1'b1;
        endcase
      end
      CYC_INDIR: begin
        case (step_i)
          T1: dp_o.mar_ld_addr = 1'b1;
          T2: mem_rd_o = 1'b1;
          T3: begin
            dp_o.mbr_ld_ptr = 1'b1;
            last_o          = 1'b1;
            next_o          = CYC_EXEC;
          end
          default: last_o = 1'b1;
        endcase
      end
      CYC_EXEC: begin
        if (ir_op_i == OP_BSA) begin
          case (step_i)
            T1: dp_o.mar_ld_addr = 1'b1;
            T2: dp_o.mbr_ld_pc = 1'b1;
            T3: mem_wr_o = 1'b1;
            T4: begin
              dp_o.pc_ld_mar1 = 1'b1;
              last_o          = 1'b1;
            end
            default: last_o = 1'b1;
          endcase
        end else if (ir_op_i == OP_ADD || ir_op_i == OP_ISZ) begin
          // shared operand fetch in t1..t3
          case (step_i)
            T1: dp_o.mar_ld_addr = 1'b1;
            T2: mem_rd_o = 1'b1;
            T3: dp_o.mbr_ld_mem = 1'b1;
            T4: begin
              if (ir_op_i == OP_ADD) begin
                dp_o.r1_add = 1'b1;
                last_o      = 1'b1;
              end else begin
                dp_o.mbr_inc = 1'b1;
              end
            end
            T5: begin
              dp_o.pc_skip_z = 1'b1;
              mem_wr_o       = 1'b1;
              last_o         = 1'b1;
            end
            default: last_o = 1'b1;
          endcase
        end else begin
          last_o = 1'b1;
        end
      end
      default: last_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dp_ctl_t       dp_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mbr_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] r1_o
);

  localparam int unsigned PADW = DW - AW;

  logic [AW-1:0] mar_q, pc_q;
  logic [DW-1:0] mbr_q, ir_q, r1_q;
  logic          mbr_zero;

  assign mbr_zero = (mbr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mar_q <= '0;
    else if (dp_i.mar_ld_pc)   mar_q <= pc_q;
    else if (dp_i.mar_ld_addr) mar_q <= mbr_q[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mbr_q <= '0;
    else if (dp_i.mbr_ld_mem) mbr_q <= rdata_i;
    else if (dp_i.mbr_ld_ptr) mbr_q <= {mbr_q[DW-1:AW], rdata_i[AW-1:0]};
    else if (dp_i.mbr_ld_pc)  mbr_q <= {{PADW{1'b0}}, pc_q};
    else if (dp_i.mbr_inc)    mbr_q <= mbr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (dp_i.pc_ld_mar1) pc_q <= mar_q + 1'b1;
    else if (dp_i.pc_inc || (dp_i.pc_skip_z && mbr_zero)) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= '0;
    else if (dp_i.ir_ld) ir_q <= mbr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r1_q <= '0;
    else if (dp_i.r1_add) r1_q <= r1_q + mbr_q;
  end

  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign r1_o  = r1_q;

endmodule

// File: rtl/uop_ctrl_core.sv
module uop_ctrl_core
  import uop_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 11,
  parameter int unsigned TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] r1_o,
  output logic [DW-1:0] ir_o,
  output logic [1:0]    cyc_o,
  output logic [TW-1:0] step_o
);

  localparam int unsigned IND_BIT = AW;

  dp_ctl_t       dp;
  logic          last;
  cyc_e          next_cyc, cyc;
  logic [TW-1:0] step;
  logic [AW-1:0] mar;
  logic [DW-1:0] mbr, ir;

  uop_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (last),
    .next_i (next_cyc),
    .cyc_o  (cyc),
    .step_o (step)
  );

  uop_decode #(.TW(TW)) u_decode (
    .cyc_i     (cyc),
    .step_i    (step),
    .ir_op_i   (ir[DW-1 -: OPW]),
    .mbr_op_i  (mbr[DW-1 -: OPW]),
    .mbr_ind_i (mbr[IND_BIT]),
    .dp_o      (dp),
    .mem_rd_o  (mem_rd_o),
    .mem_wr_o  (mem_wr_o),
    .last_o    (last),
    .next_o    (next_cyc)
  );

  uop_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dp_i    (dp),
    .rdata_i (mem_rdata_i),
    .mar_o   (mar),
    .mbr_o   (mbr),
    .pc_o    (pc_o),
    .ir_o    (ir),
    .r1_o    (r1_o)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mbr;
  assign ir_o        = ir;
  assign cyc_o       = cyc;
  assign step_o      = step;

endmodule

// File: rtl/uop_ctrl_core_chk.sv
module uop_ctrl_core_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 11,
  parameter int unsigned TW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_rd_i,
  input logic          mem_wr_i,
  input logic [1:0]    cyc_i,
  input logic [TW-1:0] step_i,
  input logic [AW-1:0] pc_i,
  input logic [DW-1:0] r1_i
);

  AST_NO_RW_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i && mem_wr_i)); // R3

  AST_WR_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> (cyc_i == 2'b10)); // R3

  AST_NO_INTR_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i != 2'b11); // R4

  AST_STEP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cyc_i) |-> (step_i == '0)); // R4

  AST_FETCH_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == 2'b00 && step_i == TW'(1)) |-> mem_rd_i); // R2

  AST_FETCH_PC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == 2'b00 && step_i == TW'(3)) |=> (pc_i == AW'($past(pc_i) + 1'b1))); // R2

  AST_R1_ONLY_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(r1_i) |-> ($past(cyc_i) == 2'b10)); // R6

endmodule

bind uop_ctrl_core uop_ctrl_core_chk #(.DW(DW), .AW(AW), .TW(TW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_rd_i (mem_rd_o),
  .mem_wr_i (mem_wr_o),
  .cyc_i    (cyc_o),
  .step_i   (step_o),
  .pc_i     (pc_o),
  .r1_i     (r1_o)
);

// File: tb/uop_ctrl_core_bench.sv
module uop_ctrl_core_bench;

  localparam int DW = 16;
  localparam int AW = 11;
  localparam int TW = 3;
  localparam int MD = 1 << AW;
  localparam int MAXI = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AW-1:0] pc;
  logic [DW-1:0] r1, ir;
  logic [1:0]    cyc;
  logic [TW-1:0] step;

  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] mem [MD];

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uop_ctrl_core #(.DW(DW), .AW(AW), .TW(TW)) u_uop_ctrl_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .pc_o        (pc),
    .r1_o        (r1),
    .ir_o        (ir),
    .cyc_o       (cyc),
    .step_o      (step)
  );

  // synchronous memory: read data appears the clock after the strobe
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // reference state
  logic [DW-1:0] init_img [MD];
  logic [DW-1:0] model [MD];
  bit            touched [MD];
  logic [DW-1:0] force_q [$];

  int            e_cyc [MAXI];
  logic [AW-1:0] e_spc [MAXI];
  logic [AW-1:0] e_pc  [MAXI];
  logic [DW-1:0] e_r1  [MAXI];
  bit            e_wr  [MAXI];
  logic [AW-1:0] e_wa  [MAXI];
  logic [DW-1:0] e_wv  [MAXI];
  string         e_tag [MAXI];

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic preset(logic [AW-1:0] a, logic [DW-1:0] v);
    init_img[a] = v;
    model[a]    = v;
    touched[a]  = 1'b1;
  endtask

  task automatic fill_random();
    for (int a = 0; a < MD; a++) begin
      logic [DW-1:0] v;
      v = DW'($urandom);
      init_img[a] = v;
      model[a]    = v;
      touched[a]  = 1'b0;
    end
    force_q.delete();
  endtask

  function automatic logic [DW-1:0] rand_instr();
    int r;
    logic [3:0] op;
    r = $urandom % 8;
    if (r < 3)       op = 4'd1;
    else if (r < 5)  op = 4'd2;
    else if (r == 5) op = 4'd3;
    else if (r == 6) op = 4'd0;
    else             op = 4'(4 + ($urandom % 12));
    return {op, 1'(($urandom % 4) == 0), AW'($urandom)};
  endfunction

  // R5: opcode [15:12], indirect flag [11], address [10:0]
  task automatic build(int n);
    logic [AW-1:0] p;
    logic [DW-1:0] acc;
    p = '0;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w, v;
      logic [3:0]    op;
      logic [AW-1:0] ea;
      int            nc;
      if (!touched[p]) begin
        if (force_q.size() > 0) w = force_q.pop_front();
        else w = rand_instr();
        preset(p, w);
      end
      w = model[p];
      op = w[15:12];
      e_spc[i] = p;
      e_wr[i] = 1'b0;
      e_wa[i] = '0;
      e_wv[i] = '0;
      p = p + 1'b1;
      nc = 4;
      if (op == 4'd1 || op == 4'd2 || op == 4'd3) begin
        ea = w[AW-1:0];
        if (w[AW]) begin
          touched[ea] = 1'b1;
          ea = model[ea][AW-1:0];
          nc += 3;
        end
        if (op == 4'd1) begin
          touched[ea] = 1'b1;
          acc = acc + model[ea];
          nc += 4;
          e_tag[i] = "R6";
        end else if (op == 4'd2) begin
          if (!touched[ea] && ($urandom % 3) == 0) preset(ea, 16'hFFFF);
          touched[ea] = 1'b1;
          v = model[ea] + 1'b1;
          model[ea] = v;
          if (v == '0) p = p + 1'b1;
          nc += 5;
          e_wr[i] = 1'b1; e_wa[i] = ea; e_wv[i] = v;
          e_tag[i] = "R7";
        end else begin
          v = {{(DW-AW){1'b0}}, p};
          model[ea] = v;
          touched[ea] = 1'b1;
          p = ea + 1'b1;
          nc += 4;
          e_wr[i] = 1'b1; e_wa[i] = ea; e_wv[i] = v;
          e_tag[i] = "R8";
        end
        if (w[AW]) e_tag[i] = {e_tag[i], "/R9"};
      end else begin
        e_tag[i] = "R10";
      end
      e_cyc[i] = nc;
      e_pc[i]  = p;
      e_r1[i]  = acc;
    end
  endtask

  task automatic run_segment(int n);
    build(n);
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < MD; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(a); ld_data = init_img[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
    rst_n = 1'b1;
    chk(pc == '0 && r1 == '0 && ir == '0, "R1", "reset pc/r1/ir", {pc, r1[4:0]}, 0);
    chk(cyc == 2'b00 && step == '0 && !mem_rd && !mem_wr, "R1", "reset state",
        {cyc, step, mem_rd, mem_wr}, 0);
    for (int i = 0; i < n; i++) begin
      chk(cyc == 2'b00 && step == '0, "R4", "fetch t1 at start", {cyc, step}, 0);
      @(negedge clk);
      chk(mem_rd && mem_addr == e_spc[i], "R2", "fetch read addr",
          {mem_rd, mem_addr}, {1'b1, e_spc[i]});
      repeat (e_cyc[i] - 1) @(negedge clk);
      chk(cyc == 2'b00 && step == '0, e_tag[i], "back at fetch t1", {cyc, step}, 0);
      chk(pc == e_pc[i], e_tag[i], "pc", pc, e_pc[i]);
      chk(r1 == e_r1[i], e_tag[i], "r1", r1, e_r1[i]);
      if (e_wr[i]) chk(mem[e_wa[i]] == e_wv[i], e_tag[i], "memory word",
                       mem[e_wa[i]], e_wv[i]);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0123);

    // R6 add, then add that wraps modulo 2^16
    fill_random();
    preset(11'h100, 16'h1234);
    preset(11'h101, 16'hF000);
    force_q.push_back({4'd1, 1'b0, 11'h100});
    force_q.push_back({4'd1, 1'b0, 11'h101});
    run_segment(2);

    // R7 skip on zero result, then no skip
    fill_random();
    preset(11'h200, 16'hFFFF);
    preset(11'h201, 16'h0005);
    force_q.push_back({4'd2, 1'b0, 11'h200});
    force_q.push_back({4'd2, 1'b0, 11'h201});
    run_segment(2);

    // R8 branch-and-save then add at target+1
    fill_random();
    preset(11'h302, 16'h0042);
    force_q.push_back({4'd3, 1'b0, 11'h300});
    force_q.push_back({4'd1, 1'b0, 11'h302});
    run_segment(2);

    // R9 indirect add and indirect branch
    fill_random();
    preset(11'h050, 16'hF3A0);
    preset(11'h3A0, 16'h0007);
    preset(11'h060, 16'h0410);
    force_q.push_back({4'd1, 1'b1, 11'h050});
    force_q.push_back({4'd3, 1'b1, 11'h060});
    run_segment(2);

    // R10 unknown opcodes including one with indirect flag set
    fill_random();
    preset(11'h020, 16'h0003);
    force_q.push_back(16'h0000);
    force_q.push_back({4'hF, 1'b1, 11'h123});
    force_q.push_back({4'd1, 1'b0, 11'h020});
    run_segment(3);

    // random programs
    for (int s = 0; s < 20; s++) begin
      fill_random();
      run_segment(30);
    end

    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule